// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It holds the trial code that an external DAC turns into a voltage. It reads back a single comparator bit that reports whether the analog input is at or above that voltage. It resolves one result bit per clock, starting at the most significant bit and ending at the least significant bit.

A conversion is requested by pulling the active-low request input low while the block is idle. The busy flag rises with the request. It stays high while the bits are being resolved and drops once the last bit has been decided. The finished code is copied into a separate result buffer on the clock after the flag falls. The buffer therefore keeps the previous answer steady while the next conversion runs in the trial register.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When `conv_req_n` is sampled low at a rising edge while `cvt_busy` is low, that edge raises `cvt_busy` and clears `trial_code` to all zeros.
- R2: On the next rising edge after R1, `trial_code` becomes 1000_0000, which puts the most significant bit under test.
- R3: At each resolving edge, the bit under test keeps the value 1 when `cmp_above` is 1 and becomes 0 when `cmp_above` is 0.
- R4: Bits are resolved one per clock, from bit 7 down to bit 0. On each resolving edge the next lower bit is set to 1, and no other bit changes. With a comparator that reports input >= `trial_code`, the final code equals the input value.
- R5: `cvt_busy` falls on the edge that resolves bit 0. That edge comes exactly 8 clocks after the edge that set the most significant bit, so the flag is high for 9 clock periods in total.
- R6: `result_code` loads the final trial code on the edge after `cvt_busy` falls. At no other time does it change, so it holds its value throughout the following conversion.
- R7: A low `conv_req_n` while `cvt_busy` is high is ignored: the trial sequence continues unchanged.
- R8: While `rst` is high at a rising edge, `trial_code` and `result_code` become zero and `cvt_busy` becomes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_req_n | input | 1 | Conversion request, active low |
| cmp_above | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| trial_code | output | 8 | Code driven to the external DAC |
| cvt_busy | output | 1 | High while a conversion is in progress |
| result_code | output | 8 | Buffered result of the last completed conversion |

## Verification
Two things can happen on the same edge. The result buffer can load the finished code of one conversion at the moment a new request clears the trial register. The bench provokes this by issuing a request on the first idle clock after `cvt_busy` falls. It then checks that the buffer holds the earlier target while the trial register starts again from zero. The bench also pulls the request low in the middle of a conversion. It judges by the trial code: every step must still follow the bit-by-bit sequence expected for the target.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARM   = 2'd1,
        PH_TRIAL = 2'd2
    } phase_e;

    typedef struct packed {
        logic clr;
        logic arm;
        logic decide;
    } step_t;

    function automatic int unsigned ptr_bits(input int unsigned width);
        return (width > 1) ? $clog2(width) : 1;
    endfunction

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned PW = ptr_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_req_n,
    output step_t         step,
    output logic [PW-1:0] ptr,
    output logic          busy
);
    localparam logic [PW-1:0] TOP_BIT = PW'(W - 1);

    phase_e phase_q;
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (!conv_req_n) begin
                        phase_q <= PH_ARM;
                    end
                end
                PH_ARM: begin
                    phase_q <= PH_TRIAL;
                    ptr_q   <= TOP_BIT;
                end
                PH_TRIAL: begin
                    if (ptr_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        ptr_q <= ptr_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        step.clr    = (phase_q == PH_IDLE) && !conv_req_n;
        step.arm    = (phase_q == PH_ARM);
        step.decide = (phase_q == PH_TRIAL);
    end

    assign ptr  = ptr_q;
    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned PW = ptr_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  step_t         step,
    input  logic [PW-1:0] ptr,
    input  logic          cmp_above,
    output logic [W-1:0]  code
);
    logic [W-1:0] code_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [PW-1:0] SELF = PW'(i);
        if (i == W - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst || step.clr) begin
                    code_q[i] <= 1'b0;
                end else if (step.arm) begin
                    code_q[i] <= 1'b1;
                end else if (step.decide && ptr == SELF) begin
                    code_q[i] <= cmp_above;
                end
            end
        end else begin : g_low
            localparam logic [PW-1:0] ABOVE = PW'(i + 1);
            always_ff @(posedge clk) begin
                if (rst || step.clr || step.arm) begin
                    code_q[i] <= 1'b0;
                end else if (step.decide) begin
                    if (ptr == SELF) begin
                        code_q[i] <= cmp_above;
                    end else if (ptr == ABOVE) begin
                        code_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign code = code_q;

endmodule

// File: rtl/sar_result_buf.sv
module sar_result_buf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         busy,
    input  logic [W-1:0] code,
    output logic [W-1:0] result
);
    logic         busy_d;
    logic [W-1:0] result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_d   <= 1'b0;
            result_q <= '0;
        end else begin
            busy_d <= busy;
            if (busy_d && !busy) begin
                result_q <= code;
            end
        end
    end

    assign result = result_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_req_n,
    input  logic         cmp_above,
    output logic [W-1:0] trial_code,
    output logic         cvt_busy,
    output logic [W-1:0] result_code
);
    localparam int unsigned PW = ptr_bits(W);

    step_t         step;
    logic [PW-1:0] ptr;
    logic          busy;
    logic [W-1:0]  code;

    sar_sequencer #(.W(W), .PW(PW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .conv_req_n (conv_req_n),
        .step       (step),
        .ptr        (ptr),
        .busy       (busy)
    );

    sar_trial_reg #(.W(W), .PW(PW)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .ptr       (ptr),
        .cmp_above (cmp_above),
        .code      (code)
    );

    sar_result_buf #(.W(W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .code   (code),
        .result (result_code)
    );

    assign trial_code = code;
    assign cvt_busy   = busy;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         conv_req_n,
    input logic         cmp_above,
    input logic [W-1:0] trial_code,
    input logic         cvt_busy,
    input logic [W-1:0] result_code
);
    localparam int unsigned LIMIT = W + 1;
    localparam int unsigned CW    = $clog2(LIMIT + 1);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !cvt_busy) begin
            run_len <= '0;
        end else if (run_len != {CW{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    a_r1_clear_on_request: assert property (@(posedge clk) disable iff (rst)
        (!cvt_busy && !conv_req_n) |=> (cvt_busy && trial_code == '0));

    a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
        (!cvt_busy && !conv_req_n) |=> ##1 (trial_code == MSB_ONLY));

    a_r4_one_new_bit: assert property (@(posedge clk) disable iff (rst)
        (cvt_busy && $past(cvt_busy)) |-> ($countones(trial_code & ~$past(trial_code)) <= 1));

    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        cvt_busy |-> (run_len < CW'(LIMIT)));

    a_r6_load_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_code) |-> ($past(cvt_busy, 2) && !$past(cvt_busy)));

    wire unused_cmp = cmp_above;

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_req_n  (conv_req_n),
    .cmp_above   (cmp_above),
    .trial_code  (trial_code),
    .cvt_busy    (cvt_busy),
    .result_code (result_code)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_req_n = 1'b1;
    logic [W-1:0] target = '0;
    logic [W-1:0] trial_code;
    logic         cvt_busy;
    logic [W-1:0] result_code;
    logic         cmp_above;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_tgt = '0;

    always #5 clk = ~clk;

    // comparator and DAC stand-in: input at or above DAC level
    assign cmp_above = (target >= trial_code);

    sar_conv_ctrl #(.W(W)) u_sar_conv_ctrl (
        .clk         (clk),
        .rst         (rst),
        .conv_req_n  (conv_req_n),
        .cmp_above   (cmp_above),
        .trial_code  (trial_code),
        .cvt_busy    (cvt_busy),
        .result_code (result_code)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: called just after a falling edge; pushes the expected result.
    task automatic run_conv(input logic [W-1:0] t, input int poke_step);
        target = t;
        conv_req_n = 1'b0;
        @(negedge clk);
        conv_req_n = 1'b1;
        exp_q.push_back(t);
        check("R1 busy", {7'd0, cvt_busy}, 8'd1);
        check("R1 clear", trial_code, 8'h00);
        check("R6 hold", result_code, last_tgt);
        @(negedge clk);
        check("R2 msb", trial_code, 8'h80);
        for (int k = 1; k <= W; k++) begin
            logic [W-1:0] hi_mask;
            logic [W-1:0] expv;
            if (k == poke_step) conv_req_n = 1'b0;   // R7 stimulus
            @(negedge clk);
            conv_req_n = 1'b1;
            hi_mask = ~(8'hFF >> k);
            expv = (t & hi_mask) | ((k < W) ? (8'h80 >> k) : 8'h00);
            check((k == poke_step) ? "R7 ignored" : "R3/R4 step", trial_code, expv);
            check("R5 busy", {7'd0, cvt_busy}, (k < W) ? 8'd1 : 8'd0);
            if (k < W) check("R6 hold", result_code, last_tgt);
        end
        last_tgt = t;
    endtask

    // Monitor: pops expected results when the buffer should load; checks run length.
    initial begin
        logic busy_prev = 1'b0;
        bit   load_due = 1'b0;
        int   run_len = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (load_due) begin
                    load_due = 1'b0;
                    if (exp_q.size() == 0) begin
                        check("R6 unexpected load", result_code, 8'hxx);
                    end else begin
                        check("R6 result", result_code, exp_q.pop_front());
                    end
                end
                if (busy_prev && !cvt_busy) begin
                    load_due = 1'b1;
                    check("R5 length", 8'(run_len), 8'd9);
                    run_len = 0;
                end
                if (cvt_busy) run_len++;
                busy_prev = cvt_busy;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 trial", trial_code, 8'h00);
        check("R8 result", result_code, 8'h00);
        check("R8 busy", {7'd0, cvt_busy}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        run_conv(8'd0, 0);
        repeat (2) @(negedge clk);
        run_conv(8'd255, 0);
        repeat (2) @(negedge clk);
        run_conv(8'd128, 0);
        repeat (2) @(negedge clk);
        run_conv(8'd1, 3);
        repeat (2) @(negedge clk);
        run_conv(8'd127, 8);
        // back-to-back: new request on the edge the buffer loads
        run_conv(8'hA5, 0);
        run_conv(8'h5A, 1);
        repeat (3) @(negedge clk);
        check("R6 final", result_code, 8'h5A);
        check("R6 queue", 8'(exp_q.size()), 8'd0);
        // reset mid-conversion
        target = 8'h33;
        conv_req_n = 1'b0;
        @(negedge clk);
        conv_req_n = 1'b1;
        void'(exp_q.pop_back());
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 trial mid", trial_code, 8'h00);
        check("R8 busy mid", {7'd0, cvt_busy}, 8'd0);
        check("R8 result mid", result_code, 8'h00);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule